// File: doc/BRIEF.md
# Word-serial descriptor ring queue

This block holds short queues of fixed-size transfer records for one DMA channel. Software builds each record on a narrow register port. It writes a 32-bit word at a time to a single address, and after the fourth word the record enters a four-slot ring. A transfer engine removes whole records from the far side. A second ring of the same shape runs the other way. The engine deposits whole completion records into it, and software drains them one word per read strobe.

Each ring publishes a packed status word, and the bit positions in that word are fixed. The word carries both slot indices, empty and full flags, and a sticky error flag that is cleared by writing a one. A pushed record that finds the ring full is lost and raises the error flag. A pop that finds the ring empty returns zeros and also raises the error flag. A shared ring-reset input rewinds both rings and drops any record that was only partly written.

Top module: `desc_ring_queue`

## Requirements
- R1: After `rst`, both status words read 0x0000_0100: both slots are 0, the empty bit is set, and the full and error bits are clear.
- R2: Four `dw_en` writes commit one record, and the write slot advances only on the fourth write. The first word lands in bits [31:0] of the record and the fourth word in bits [127:96], so the order is address low, address high, byte length, flags.
- R3: Status layout: write slot in [1:0], read slot in [5:4], empty in bit 8, full in bit 9, error in bit 10, and all other bits zero. When the slots differ, occupancy is (write − read + 4) mod 4. When they are equal, exactly one of full or empty is set.
- R4: The descriptor ring holds four records. A fourth word written while it is full discards the record, sets the error bit and leaves both slots unchanged.
- R5: A `dq_pop` presents the oldest record on `dq_entry` one cycle later, in first-in first-out order. `dq_notify` is bit 16 of that record's flags word (record bit 112).
- R6: A `dq_pop` on an empty descriptor ring returns an all-zero record with `dq_notify` low, sets the error bit and leaves the slots unchanged.
- R7: The error bit is sticky. A status write with bit 10 set clears it, and a status write with bit 10 clear has no effect. If a new error occurs in the same cycle as a clear, the bit stays set.
- R8: A `ring_rst` cycle clears the slots and the word counters of both rings, so a partly written or partly read record is dropped. It leaves the error bits unchanged.
- R9: `rp_push` stores a whole record in the report ring. Successive `rr_rd` strobes return its words on `rr_data` one cycle later, lowest word first, and the slot is freed by the fourth read.
- R10: An `rr_rd` on an empty report ring returns zero and sets the report error bit.
- R11: An `rp_push` while the report ring is full is discarded and sets the report error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_rst | input | 1 | Rewinds both rings while high |
| dw_en | input | 1 | Descriptor word write strobe |
| dw_data | input | 32 | Descriptor word |
| dstat_wr | input | 1 | Descriptor status write strobe |
| dstat_wdata | input | 32 | Descriptor status write data (bit 10 clears error) |
| dstat | output | 32 | Descriptor ring status |
| dq_pop | input | 1 | Engine takes one descriptor |
| dq_entry | output | 128 | Descriptor taken, registered |
| dq_notify | output | 1 | Completion notification requested by that descriptor |
| rp_push | input | 1 | Engine deposits one report |
| rp_entry | input | 128 | Report record |
| rr_rd | input | 1 | Report word read strobe |
| rr_data | output | 32 | Report word read, registered |
| rstat_wr | input | 1 | Report status write strobe |
| rstat_wdata | input | 32 | Report status write data (bit 10 clears error) |
| rstat | output | 32 | Report ring status |

## Verification
The bench targets the full-versus-empty ambiguity when both slots match. A design that decides the flags from the slots alone reads a full ring as empty. It also targets the fifth record written into a full ring: a design that fails to drop it overwrites the oldest record and advances the write slot. Other cases covered are a ring reset that lands mid-record, which a design without a counter clear would turn into a record with shifted words, and an error clear that lands in the same cycle as a fresh empty pop, where a design that lets the clear win would lose the error. Seeded random traffic on both rings is compared word by word against a reference model in the bench.

// File: rtl/dring_pkg.sv
package dring_pkg;
  localparam int ST_RD_LSB   = 4;
  localparam int ST_EMPTY    = 8;
  localparam int ST_FULL     = 9;
  localparam int ST_ERR      = 10;
  localparam int NOTIFY_BIT  = 16;

  function automatic logic [31:0] pack_status(input logic [3:0] wr_slot,
                                              input logic [3:0] rd_slot,
                                              input logic is_empty,
                                              input logic is_full,
                                              input logic has_err);
    logic [31:0] s;
    s = '0;
    s[3:0] = wr_slot;
    s[ST_RD_LSB +: 4] = rd_slot;
    s[ST_EMPTY] = is_empty;
    s[ST_FULL]  = is_full;
    s[ST_ERR]   = has_err;
    return s;
  endfunction
endpackage

// File: rtl/word_assembler.sv
module word_assembler #(
  parameter int WORD_W = 32,
  parameter int NWORDS = 4,
  localparam int IDX_W = $clog2(NWORDS),
  localparam int ENT_W = WORD_W * NWORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic              push,
  output logic [ENT_W-1:0]  entry
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NWORDS - 1);

  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] held [NWORDS-1];

  always_ff @(posedge clk) begin
    if (rst || clr) idx <= '0;
    else if (wr_en) idx <= (idx == LAST) ? '0 : idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr && idx != LAST) held[idx] <= wdata;
  end

  always_comb begin
    for (int i = 0; i < NWORDS - 1; i++) entry[i*WORD_W +: WORD_W] = held[i];
    entry[(NWORDS-1)*WORD_W +: WORD_W] = wdata;
  end

  assign push = wr_en && !clr && (idx == LAST);

  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clr && idx == LAST) |=> (idx == '0));
  p_clr_idx_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (idx == '0));
endmodule

// File: rtl/slot_ring.sv
module slot_ring #(
  parameter int ENTRY_W = 128,
  parameter int DEPTH   = 4,
  localparam int SLOT_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               push,
  input  logic [ENTRY_W-1:0] push_data,
  input  logic               pop,
  input  logic               err_clr,
  output logic [ENTRY_W-1:0] head,
  output logic [SLOT_W-1:0]  wr_slot,
  output logic [SLOT_W-1:0]  rd_slot,
  output logic               empty,
  output logic               full,
  output logic               err
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(DEPTH);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [SLOT_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]   count;
  logic push_ok, pop_ok, bad;

  assign full    = (count == FULL_CNT);
  assign empty   = (count == '0);
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;
  assign bad     = !clr && ((push && full) || (pop && empty));

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end
  assign head = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST_SLOT) ? '0 : rd_ptr + 1'b1;
      count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          err <= 1'b0;
    else if (bad)     err <= 1'b1;
    else if (err_clr) err <= 1'b0;
  end

  assign wr_slot = wr_ptr;
  assign rd_slot = rd_ptr;

  p_flags_excl_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_ptr == rd_ptr) |-> (full ^ empty));
  p_occupancy_r3: assert property (@(posedge clk) disable iff (rst)
    !full |-> (int'(count) == (int'(wr_ptr) + DEPTH - int'(rd_ptr)) % DEPTH));
  p_full_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !clr) |=> ($stable(wr_ptr) && full && err));
  p_empty_pop_r6: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !clr) |=> (err && $stable(rd_ptr)));
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (err && !err_clr) |=> err);
  p_ring_rst_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (empty && wr_ptr == '0 && rd_ptr == '0));
endmodule

// File: rtl/word_serializer.sv
module word_serializer #(
  parameter int WORD_W = 32,
  parameter int NWORDS = 4,
  localparam int IDX_W = $clog2(NWORDS),
  localparam int ENT_W = WORD_W * NWORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              rd,
  input  logic              empty,
  input  logic [ENT_W-1:0]  head,
  output logic              pop,
  output logic [WORD_W-1:0] rdata
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NWORDS - 1);

  logic [IDX_W-1:0] idx;

  assign pop = rd && !clr && (empty || idx == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx   <= '0;
      rdata <= '0;
    end else if (clr) begin
      idx <= '0;
    end else if (rd) begin
      if (empty) begin
        rdata <= '0;
      end else begin
        rdata <= head[int'(idx)*WORD_W +: WORD_W];
        idx   <= (idx == LAST) ? '0 : idx + 1'b1;
      end
    end
  end

  p_empty_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (rd && empty && !clr) |=> (rdata == '0));
  p_hold_idx_r10: assert property (@(posedge clk) disable iff (rst)
    (rd && empty && !clr) |=> $stable(idx));
endmodule

// File: rtl/desc_ring_queue.sv
module desc_ring_queue
  import dring_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int NWORDS = 4,
  parameter int DEPTH  = 4,
  localparam int ENT_W  = WORD_W * NWORDS,
  localparam int SLOT_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ring_rst,
  input  logic              dw_en,
  input  logic [WORD_W-1:0] dw_data,
  input  logic              dstat_wr,
  input  logic [31:0]       dstat_wdata,
  output logic [31:0]       dstat,
  input  logic              dq_pop,
  output logic [ENT_W-1:0]  dq_entry,
  output logic              dq_notify,
  input  logic              rp_push,
  input  logic [ENT_W-1:0]  rp_entry,
  input  logic              rr_rd,
  output logic [WORD_W-1:0] rr_data,
  input  logic              rstat_wr,
  input  logic [31:0]       rstat_wdata,
  output logic [31:0]       rstat
);
  localparam int NOTIFY_POS = (NWORDS - 1) * WORD_W + NOTIFY_BIT;

  logic             a_push;
  logic [ENT_W-1:0] a_entry, d_head, r_head;
  logic [SLOT_W-1:0] d_wr, d_rd, r_wr, r_rd;
  logic d_empty, d_full, d_err, r_empty, r_full, r_err, r_pop;
  logic unused_wbits;

  assign unused_wbits = ^{dstat_wdata[31:ST_ERR+1], dstat_wdata[ST_ERR-1:0],
                          rstat_wdata[31:ST_ERR+1], rstat_wdata[ST_ERR-1:0]};

  word_assembler #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_dasm (
    .clk(clk), .rst(rst), .clr(ring_rst), .wr_en(dw_en), .wdata(dw_data),
    .push(a_push), .entry(a_entry));

  slot_ring #(.ENTRY_W(ENT_W), .DEPTH(DEPTH)) u_dring (
    .clk(clk), .rst(rst), .clr(ring_rst), .push(a_push), .push_data(a_entry),
    .pop(dq_pop), .err_clr(dstat_wr && dstat_wdata[ST_ERR]), .head(d_head),
    .wr_slot(d_wr), .rd_slot(d_rd), .empty(d_empty), .full(d_full), .err(d_err));

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_entry  <= '0;
      dq_notify <= 1'b0;
    end else if (dq_pop && !ring_rst) begin
      dq_entry  <= d_empty ? '0 : d_head;
      dq_notify <= !d_empty && d_head[NOTIFY_POS];
    end
  end

  slot_ring #(.ENTRY_W(ENT_W), .DEPTH(DEPTH)) u_rring (
    .clk(clk), .rst(rst), .clr(ring_rst), .push(rp_push), .push_data(rp_entry),
    .pop(r_pop), .err_clr(rstat_wr && rstat_wdata[ST_ERR]), .head(r_head),
    .wr_slot(r_wr), .rd_slot(r_rd), .empty(r_empty), .full(r_full), .err(r_err));

  word_serializer #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_rser (
    .clk(clk), .rst(rst), .clr(ring_rst), .rd(rr_rd), .empty(r_empty),
    .head(r_head), .pop(r_pop), .rdata(rr_data));

  assign dstat = pack_status(4'(d_wr), 4'(d_rd), d_empty, d_full, d_err);
  assign rstat = pack_status(4'(r_wr), 4'(r_rd), r_empty, r_full, r_err);

  p_empty_entry_r6: assert property (@(posedge clk) disable iff (rst)
    (dq_pop && d_empty && !ring_rst) |=> (dq_entry == '0 && !dq_notify));
endmodule

// File: tb/sim_desc_ring_queue.sv
module sim_desc_ring_queue;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ring_rst = 1'b0;
  logic dw_en = 1'b0;
  logic [31:0] dw_data = '0;
  logic dstat_wr = 1'b0;
  logic [31:0] dstat_wdata = '0;
  logic [31:0] dstat;
  logic dq_pop = 1'b0;
  logic [127:0] dq_entry;
  logic dq_notify;
  logic rp_push = 1'b0;
  logic [127:0] rp_entry = '0;
  logic rr_rd = 1'b0;
  logic [31:0] rr_data;
  logic rstat_wr = 1'b0;
  logic [31:0] rstat_wdata = '0;
  logic [31:0] rstat;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [127:0] md_mem [4];
  logic [31:0]  md_part [3];
  int md_wr = 0, md_rd = 0, md_cnt = 0, md_widx = 0;
  bit md_err = 1'b0;
  logic [127:0] mr_mem [4];
  int mr_wr = 0, mr_rd = 0, mr_cnt = 0, mr_ridx = 0;
  bit mr_err = 1'b0;

  always #10 clk = ~clk;

  desc_ring_queue u0 (
    .clk(clk), .rst(rst), .ring_rst(ring_rst), .dw_en(dw_en), .dw_data(dw_data),
    .dstat_wr(dstat_wr), .dstat_wdata(dstat_wdata), .dstat(dstat),
    .dq_pop(dq_pop), .dq_entry(dq_entry), .dq_notify(dq_notify),
    .rp_push(rp_push), .rp_entry(rp_entry), .rr_rd(rr_rd), .rr_data(rr_data),
    .rstat_wr(rstat_wr), .rstat_wdata(rstat_wdata), .rstat(rstat));

  function automatic logic [31:0] stat_of(int wr, int rd, int cnt, bit err);
    logic [31:0] s;
    s = 32'(wr) | (32'(rd) << 4);
    if (cnt == 0) s |= 32'h100;
    if (cnt == 4) s |= 32'h200;
    if (err) s |= 32'h400;
    return s;
  endfunction

  function automatic logic [127:0] rand_entry(bit notify);
    logic [127:0] e;
    e = {$urandom, $urandom, $urandom, $urandom};
    e[112] = notify;
    return e;
  endfunction

  task automatic check(string req, string what, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic stat_check(string req);
    check(req, "dstat", 128'(dstat), 128'(stat_of(md_wr, md_rd, md_cnt, md_err)));
    check(req, "rstat", 128'(rstat), 128'(stat_of(mr_wr, mr_rd, mr_cnt, mr_err)));
  endtask

  task automatic d_write(logic [31:0] w);
    @(negedge clk); dw_en = 1'b1; dw_data = w;
    @(negedge clk); dw_en = 1'b0;
    if (md_widx < 3) begin
      md_part[md_widx] = w; md_widx++;
    end else begin
      md_widx = 0;
      if (md_cnt == 4) md_err = 1'b1;
      else begin
        md_mem[md_wr] = {w, md_part[2], md_part[1], md_part[0]};
        md_wr = (md_wr + 1) % 4; md_cnt++;
      end
    end
  endtask

  task automatic d_entry(logic [127:0] e);
    for (int i = 0; i < 4; i++) d_write(e[i*32 +: 32]);
  endtask

  task automatic d_pop(string req);
    logic [127:0] exp_e;
    @(negedge clk); dq_pop = 1'b1;
    @(negedge clk); dq_pop = 1'b0;
    if (md_cnt == 0) begin
      exp_e = '0; md_err = 1'b1;
    end else begin
      exp_e = md_mem[md_rd]; md_rd = (md_rd + 1) % 4; md_cnt--;
    end
    check(req, "dq_entry", dq_entry, exp_e);
    check(req, "dq_notify", 128'(dq_notify), 128'(exp_e[112]));
  endtask

  task automatic r_push(logic [127:0] e);
    @(negedge clk); rp_push = 1'b1; rp_entry = e;
    @(negedge clk); rp_push = 1'b0;
    if (mr_cnt == 4) mr_err = 1'b1;
    else begin
      mr_mem[mr_wr] = e; mr_wr = (mr_wr + 1) % 4; mr_cnt++;
    end
  endtask

  task automatic r_read(string req);
    logic [31:0] exp_w;
    @(negedge clk); rr_rd = 1'b1;
    @(negedge clk); rr_rd = 1'b0;
    if (mr_cnt == 0) begin
      exp_w = '0; mr_err = 1'b1;
    end else begin
      exp_w = mr_mem[mr_rd][mr_ridx*32 +: 32];
      mr_ridx++;
      if (mr_ridx == 4) begin
        mr_ridx = 0; mr_rd = (mr_rd + 1) % 4; mr_cnt--;
      end
    end
    check(req, "rr_data", 128'(rr_data), 128'(exp_w));
  endtask

  task automatic d_clear(logic [31:0] d);
    @(negedge clk); dstat_wr = 1'b1; dstat_wdata = d;
    @(negedge clk); dstat_wr = 1'b0;
    if (d[10]) md_err = 1'b0;
  endtask

  task automatic r_clear(logic [31:0] d);
    @(negedge clk); rstat_wr = 1'b1; rstat_wdata = d;
    @(negedge clk); rstat_wr = 1'b0;
    if (d[10]) mr_err = 1'b0;
  endtask

  task automatic pulse_ring_rst();
    @(negedge clk); ring_rst = 1'b1;
    @(negedge clk); ring_rst = 1'b0;
    md_wr = 0; md_rd = 0; md_cnt = 0; md_widx = 0;
    mr_wr = 0; mr_rd = 0; mr_cnt = 0; mr_ridx = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state of both rings
    check("R1", "dstat", 128'(dstat), 128'(32'h100));
    check("R1", "rstat", 128'(rstat), 128'(32'h100));

    // R2: slot advances only on the fourth word
    d_write(32'h1111_0000); d_write(32'h2222_0000); d_write(32'h0000_0040);
    check("R2", "dstat after 3 words", 128'(dstat), 128'(32'h100));
    d_write(32'h0001_0000);
    check("R2", "dstat after 4 words", 128'(dstat), 128'(32'h001));
    // R5: word order and notify flag
    d_pop("R5");
    check("R2", "word order", 128'(md_mem[0]),
          {32'h0001_0000, 32'h0000_0040, 32'h2222_0000, 32'h1111_0000});
    stat_check("R3");
    // R6: empty pop
    d_pop("R6");
    stat_check("R6");
    // R7: clear without bit 10 does nothing, with bit 10 clears
    d_clear(32'hFFFF_FBFF);
    stat_check("R7");
    d_clear(32'h0000_0400);
    stat_check("R7");

    // R4: fill, overflow, drain in order
    for (int i = 0; i < 4; i++) d_entry(rand_entry(i[0]));
    stat_check("R4");
    check("R3", "full with equal slots", 128'(dstat[9:8]), 128'(2'b10));
    d_entry(rand_entry(1'b1));
    stat_check("R4");
    for (int i = 0; i < 4; i++) d_pop("R5");
    stat_check("R3");

    // R7: clear colliding with a new error keeps the bit
    d_clear(32'h400);
    @(negedge clk); dq_pop = 1'b1; dstat_wr = 1'b1; dstat_wdata = 32'h400;
    @(negedge clk); dq_pop = 1'b0; dstat_wr = 1'b0;
    md_err = 1'b1;
    check("R7", "error wins over clear", 128'(dstat[10]), 128'(1'b1));
    d_clear(32'h400);

    // R8: ring reset mid-record on both rings, error preserved
    d_entry(rand_entry(1'b0));
    d_pop("R5"); d_pop("R6");
    d_write(32'hDEAD_0001); d_write(32'hDEAD_0002);
    r_push(rand_entry(1'b0)); r_push(rand_entry(1'b1));
    r_read("R9");
    pulse_ring_rst();
    stat_check("R8");
    d_entry(rand_entry(1'b1));
    d_pop("R8");
    r_push(rand_entry(1'b0));
    for (int i = 0; i < 4; i++) r_read("R8");
    stat_check("R8");
    d_clear(32'h400);

    // R9: report words in order, slot freed on fourth read
    r_push(rand_entry(1'b1));
    for (int i = 0; i < 3; i++) r_read("R9");
    stat_check("R9");
    r_read("R9");
    stat_check("R9");
    // R10: empty serial read
    r_read("R10");
    stat_check("R10");
    r_clear(32'h400);
    // R11: report overflow
    for (int i = 0; i < 5; i++) r_push(rand_entry(1'b0));
    stat_check("R11");
    for (int i = 0; i < 16; i++) r_read("R9");
    stat_check("R11");
    r_clear(32'h400);

    // random mix, all requirements compared against the model
    for (int k = 0; k < 500; k++) begin
      int op;
      op = int'($urandom_range(0, 19));
      if (op <= 6) d_write(op == 6 ? ($urandom | 32'h0001_0000) : $urandom);
      else if (op <= 9) d_pop("R5");
      else if (op <= 13) r_push(rand_entry(1'($urandom)));
      else if (op <= 17) r_read("R9");
      else if (op == 18) begin
        if ($urandom_range(0, 1) == 0) d_clear($urandom);
        else r_clear($urandom);
      end else if ($urandom_range(0, 3) == 0) pulse_ring_rst();
      stat_check("R3");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule